// File: doc/BRIEF.md
# Bidirectional PCM Sample FIFO

This block is the sample buffer between a processor register port and a byte-wide PCM codec. A single 16-entry byte queue serves both directions. A periodic sample tick, nominally 8 kHz and produced elsewhere, moves one byte per tick. The direction bit selects what the tick does. In record mode the tick captures the codec input byte into the queue. In playback mode the tick sends the oldest queued byte to the codec output and pulses a strobe.

The processor side has a write strobe and a read strobe on a sound data register. A write stores the low byte of the bus word. The read data port always shows the oldest byte, and a read strobe removes that byte. The block exports a full flag. It also raises a sound interrupt request on every enabled tick, and that request stays up until the processor acknowledges it.

Processor accesses and tick accesses may fall in the same cycle. When they do, both are applied, and the occupancy changes by the net amount.

Top module: `pcm_sample_fifo`

## Requirements
- R1: After reset the queue is empty, `full`, `irq`, `pcm_out_vld` and `pcm_out` are 0, and `cpu_rdata` reads 0x00.
- R2: A cycle with `tick`, `snd_en` and `snd_dir`=0 (record) appends `pcm_in` to the queue, provided the queue held fewer than 16 bytes at the start of the cycle. Bytes come back out oldest first.
- R3: A cycle with `tick`, `snd_en` and `snd_dir`=1 (playback) on a non-empty queue removes a byte. In the following cycle `pcm_out` holds that byte and `pcm_out_vld` is 1 for exactly one cycle. On an empty queue there is no strobe, and `pcm_out` keeps its previous value at all times when no strobe occurs.
- R4: A `tick` while `snd_en` is 0 changes neither the queue contents nor `irq`.
- R5: `cpu_wr` appends bits [7:0] of `cpu_wdata`. A write that finds no free slot is dropped.
- R6: `cpu_rdata` shows the oldest byte combinationally, or 0x00 when the queue is empty. `cpu_rd` removes that byte. A read of an empty queue leaves the queue unchanged.
- R7: `full` is 1 in the cycle after an update that leaves 16 bytes in the queue, and 0 after any update that leaves fewer.
- R8: Every enabled tick sets `irq`, whether or not a byte moved. `irq` stays set until `irq_ack` is 1 in a cycle without an enabled tick. An enabled tick wins over an acknowledge in the same cycle.
- R9: Same-cycle accesses are both applied and judged against the occupancy at the start of the cycle. For pushes, the tick byte takes capacity first and is queued ahead of the processor byte. For pops, the processor gets the oldest byte and the codec gets the next one.
- R10: The queue never holds more than 16 bytes. Sixteen accepted pushes make it full, and a seventeenth push is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_en | input | 1 | Sound enable; ticks are ignored while low |
| snd_dir | input | 1 | 0 = record (codec to queue), 1 = playback (queue to codec) |
| tick | input | 1 | One-cycle sample tick |
| cpu_wr | input | 1 | Processor write strobe for the sound data register |
| cpu_wdata | input | 16 | Processor write word; low byte is queued |
| cpu_rd | input | 1 | Processor read strobe; pops the oldest byte |
| cpu_rdata | output | 8 | Oldest queued byte, 0x00 when empty |
| pcm_in | input | 8 | Codec input sample |
| pcm_out | output | 8 | Codec output sample |
| pcm_out_vld | output | 1 | One-cycle strobe for a new `pcm_out` byte |
| full | output | 1 | Queue holds 16 bytes |
| irq_ack | input | 1 | Write-one-to-clear acknowledge for `irq` |
| irq | output | 1 | Sound interrupt request |

## Verification
The directed phases each use one kind of traffic. Processor-only writes and reads check byte selection and ordering. A record stream longer than the queue tells accepted captures apart from dropped ones. Playback beyond the queue contents tells real strobes apart from empty ticks. Disabled ticks show that the enable gates both data movement and the interrupt. Targeted same-cycle collisions at empty, nearly full and full show which side gets the capacity and which byte each reader receives. A long pseudo-random mix of all inputs then compares every output against a queue model on each clock, to catch interactions the directed cases miss.

// File: rtl/pcm_fifo_pkg.sv
package pcm_fifo_pkg;

    localparam int PCM_DEPTH = 16;
    localparam int PCM_DW    = 8;
    localparam int PCM_BUS_W = 16;

    // Which of the four possible queue operations are granted this cycle
    typedef struct packed {
        logic tick_push;
        logic tick_pop;
        logic cpu_push;
        logic cpu_pop;
    } pcm_grant_t;

endpackage

// File: rtl/pcm_grant.sv
module pcm_grant
    import pcm_fifo_pkg::*;
#(
    parameter int DEPTH = PCM_DEPTH,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic [CW-1:0] cnt,
    input  logic          snd_en,
    input  logic          snd_dir,
    input  logic          tick,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    output pcm_grant_t    grant
);

    logic live_tick;

    always_comb begin
        live_tick        = snd_en & tick;
        grant.tick_push  = live_tick & ~snd_dir & (cnt < CW'(DEPTH));
        grant.cpu_pop    = cpu_rd & (cnt != '0);
        grant.tick_pop   = live_tick & snd_dir & (cnt > CW'(grant.cpu_pop));
        grant.cpu_push   = cpu_wr & ((cnt + CW'(grant.tick_push)) < CW'(DEPTH));
    end

endmodule

// File: rtl/pcm_ring.sv
module pcm_ring
    import pcm_fifo_pkg::*;
#(
    parameter int DEPTH = PCM_DEPTH,
    parameter int DW    = PCM_DW,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pcm_grant_t    grant,
    input  logic [DW-1:0] tick_wdata,
    input  logic [DW-1:0] cpu_wdata,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic [DW-1:0] head_data,
    output logic [DW-1:0] tick_rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
        logic                     full;
    } ring_t;

    ring_t         s_d, s_q;
    logic [AW-1:0] cpu_wp;
    logic [AW-1:0] tick_rp;

    always_comb begin
        s_d     = s_q;
        cpu_wp  = s_q.wp + AW'(grant.tick_push);
        tick_rp = s_q.rp + AW'(grant.cpu_pop);
        if (grant.tick_push) s_d.mem[s_q.wp] = tick_wdata;
        if (grant.cpu_push)  s_d.mem[cpu_wp] = cpu_wdata;
        s_d.wp   = cpu_wp + AW'(grant.cpu_push);
        s_d.rp   = tick_rp + AW'(grant.tick_pop);
        s_d.cnt  = s_q.cnt + CW'(grant.tick_push) + CW'(grant.cpu_push)
                 - CW'(grant.cpu_pop) - CW'(grant.tick_pop);
        s_d.full = (s_d.cnt == CW'(DEPTH));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt        = s_q.cnt;
    assign full       = s_q.full;
    assign head_data  = (s_q.cnt != '0) ? s_q.mem[s_q.rp] : '0;
    assign tick_rdata = s_q.mem[tick_rp];

    // R10: occupancy bounded by the depth
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));

    // R7: an update that reaches the depth raises the flag next cycle
    assert_full_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CW'(DEPTH - 1) && (grant.tick_push || grant.cpu_push)
         && !grant.cpu_pop && !grant.tick_pop) |=> full);

    // R6: pops never granted on an empty queue
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == '0) |-> !(grant.cpu_pop || grant.tick_pop));

endmodule

// File: rtl/pcm_irq.sv
module pcm_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic live_tick,
    input  logic ack,
    output logic irq
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (ack)       irq_d = 1'b0;
        if (live_tick) irq_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    // R8: an enabled tick always leaves the request raised
    assert_tick_sets_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        live_tick |=> irq);

    // R8: acknowledge without a tick drops the request
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !live_tick) |=> !irq);

    // R4: without an enabled tick the request cannot appear
    assert_no_spurious_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !live_tick) |=> !irq);

endmodule

// File: rtl/pcm_sample_fifo.sv
module pcm_sample_fifo
    import pcm_fifo_pkg::*;
#(
    parameter int DEPTH = PCM_DEPTH,
    parameter int DW    = PCM_DW,
    parameter int BUS_W = PCM_BUS_W,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snd_en,
    input  logic             snd_dir,
    input  logic             tick,
    input  logic             cpu_wr,
    input  logic [BUS_W-1:0] cpu_wdata,
    input  logic             cpu_rd,
    output logic [DW-1:0]    cpu_rdata,
    input  logic [DW-1:0]    pcm_in,
    output logic [DW-1:0]    pcm_out,
    output logic             pcm_out_vld,
    output logic             full,
    input  logic             irq_ack,
    output logic             irq
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          vld;
    } out_t;

    pcm_grant_t    grant;
    logic [CW-1:0] cnt;
    logic [DW-1:0] tick_rdata;
    out_t          o_d, o_q;

    pcm_grant #(.DEPTH(DEPTH)) u_grant (
        .cnt     (cnt),
        .snd_en  (snd_en),
        .snd_dir (snd_dir),
        .tick    (tick),
        .cpu_wr  (cpu_wr),
        .cpu_rd  (cpu_rd),
        .grant   (grant)
    );

    pcm_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant      (grant),
        .tick_wdata (pcm_in),
        .cpu_wdata  (cpu_wdata[DW-1:0]),
        .cnt        (cnt),
        .full       (full),
        .head_data  (cpu_rdata),
        .tick_rdata (tick_rdata)
    );

    pcm_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .live_tick (snd_en & tick),
        .ack       (irq_ack),
        .irq       (irq)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = grant.tick_pop;
        if (grant.tick_pop) o_d.data = tick_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign pcm_out     = o_q.data;
    assign pcm_out_vld = o_q.vld;

    // R3: a strobe only follows an enabled playback tick
    assert_strobe_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_out_vld |-> $past(snd_en && snd_dir && tick));

    // R3: without a strobe the codec byte holds
    assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pcm_out_vld |-> $stable(pcm_out));

    // R5: a write into a full queue with no pop leaves it full
    assert_drop_on_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DEPTH) && cpu_wr && !cpu_rd && !(snd_en && tick && snd_dir))
        |=> (cnt == CW'(DEPTH)));

    // R6: a read of an empty queue with no push leaves it empty
    assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && cpu_rd && !cpu_wr && !(snd_en && tick && !snd_dir))
        |=> (cnt == '0));

endmodule

// File: tb/pcm_sample_fifo_tb.sv
module pcm_sample_fifo_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        snd_en, snd_dir, tick, cpu_wr, cpu_rd, irq_ack;
    logic [15:0] cpu_wdata;
    logic [7:0]  pcm_in;
    logic [7:0]  cpu_rdata, pcm_out;
    logic        pcm_out_vld, full, irq;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // reference model
    byte unsigned q[$];
    bit           m_irq;
    byte unsigned m_out;
    bit           m_vld;

    always #5 clk = ~clk;

    pcm_sample_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .snd_en(snd_en), .snd_dir(snd_dir), .tick(tick),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .pcm_in(pcm_in), .pcm_out(pcm_out), .pcm_out_vld(pcm_out_vld), .full(full),
        .irq_ack(irq_ack), .irq(irq)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int model_head();
        return (q.size() != 0) ? int'(q[0]) : 0;
    endfunction

    // One clock: inputs are driven at the falling edge, the read port is
    // checked before the rising edge, registered outputs just after it.
    task automatic cyc(bit en, bit dir, bit tk, bit wr, logic [15:0] wd,
                       bit rd, logic [7:0] pin, bit ack);
        int  n0;
        bit  cpop, tpop, tpush, cpush;
        snd_en = en; snd_dir = dir; tick = tk; cpu_wr = wr; cpu_wdata = wd;
        cpu_rd = rd; pcm_in = pin; irq_ack = ack;
        #1;
        chk("R6", "cpu_rdata", cpu_rdata, model_head());
        n0    = q.size();
        cpop  = rd && n0 > 0;
        tpop  = en && tk && dir && n0 > int'(cpop);
        tpush = en && tk && !dir && n0 < 16;
        cpush = wr && (n0 + int'(tpush)) < 16;
        if (cpop) void'(q.pop_front());
        m_vld = tpop;
        if (tpop) m_out = q.pop_front();
        if (tpush) q.push_back(pin);
        if (cpush) q.push_back(wd[7:0]);
        if (ack) m_irq = 0;
        if (en && tk) m_irq = 1;
        @(posedge clk);
        #1;
        chk("R7", "full", full, q.size() == 16);
        chk("R8", "irq", irq, m_irq);
        chk("R3", "pcm_out_vld", pcm_out_vld, m_vld);
        chk("R3", "pcm_out", pcm_out, m_out);
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 16'h0, 0, 8'h0, 0);
    endtask

    initial begin
        rst_n = 0; snd_en = 0; snd_dir = 0; tick = 0; cpu_wr = 0; cpu_rd = 0;
        irq_ack = 0; cpu_wdata = '0; pcm_in = '0;
        m_irq = 0; m_out = 0; m_vld = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1", "full after reset", full, 0);
        chk("R1", "irq after reset", irq, 0);
        chk("R1", "pcm_out_vld after reset", pcm_out_vld, 0);
        chk("R1", "pcm_out after reset", pcm_out, 0);
        chk("R1", "cpu_rdata after reset", cpu_rdata, 0);
        @(negedge clk);

        // R5 processor writes take the low byte; R6 reads oldest first
        cyc(0, 0, 0, 1, 16'hAB12, 0, 8'h0, 0);
        cyc(0, 0, 0, 1, 16'hCD34, 0, 8'h0, 0);
        cyc(0, 0, 0, 1, 16'hEF56, 0, 8'h0, 0);
        #1 chk("R5", "low byte queued", cpu_rdata, 8'h12);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 16'h0, 1, 8'h0, 0);
        #1 chk("R6", "empty read data", cpu_rdata, 0);

        // R2 / R10 record 20 ticks into a 16-entry queue
        for (int i = 0; i < 20; i++) cyc(1, 0, 1, 0, 16'h0, 0, 8'(i * 7 + 3), 0);
        chk("R10", "full after 20 captures", full, 1);
        cyc(0, 0, 0, 0, 16'h0, 0, 8'h0, 1);
        chk("R8", "irq cleared by ack", irq, 0);
        // R5 write dropped when full
        cyc(0, 0, 0, 1, 16'h00EE, 0, 8'h0, 0);
        for (int i = 0; i < 16; i++) begin
            #1 chk("R2", "capture order", cpu_rdata, 8'(i * 7 + 3));
            cyc(0, 0, 0, 0, 16'h0, 1, 8'h0, 0);
        end
        #1 chk("R10", "empty after 16 reads", cpu_rdata, 0);

        // R4 ticks while disabled do nothing
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 16'h0, 0, 8'h55, 0);
        chk("R4", "irq stays low", irq, 0);
        #1 chk("R4", "queue stays empty", cpu_rdata, 0);
        cyc(0, 1, 1, 1, 16'h0077, 0, 8'h0, 0);
        chk("R4", "no playback when disabled", pcm_out_vld, 0);
        cyc(0, 0, 0, 0, 16'h0, 1, 8'h0, 0);

        // R3 playback beyond the queue contents
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 16'(8'hA0 + i), 0, 8'h0, 0);
        for (int i = 0; i < 7; i++) cyc(1, 1, 1, 0, 16'h0, 0, 8'h0, 0);
        chk("R3", "last byte held after empty ticks", pcm_out, 8'hA4);

        // R8 tick wins over acknowledge
        cyc(1, 1, 1, 0, 16'h0, 0, 8'h0, 1);
        chk("R8", "tick beats ack", irq, 1);
        cyc(0, 0, 0, 0, 16'h0, 0, 8'h0, 1);

        // R9 collisions
        cyc(0, 0, 0, 1, 16'h0011, 0, 8'h0, 0);
        cyc(0, 0, 0, 1, 16'h0022, 0, 8'h0, 0);
        cyc(1, 1, 1, 0, 16'h0, 1, 8'h0, 0);
        chk("R9", "codec gets second byte", pcm_out, 8'h22);
        cyc(1, 0, 1, 1, 16'h0044, 0, 8'h33, 0);
        #1 chk("R9", "tick byte ahead of cpu byte", cpu_rdata, 8'h33);
        for (int i = 0; i < 13; i++) cyc(0, 0, 0, 1, 16'(i), 0, 8'h0, 0);
        cyc(1, 0, 1, 1, 16'h0099, 0, 8'h66, 0);
        chk("R9", "tick takes last slot", full, 1);
        cyc(1, 0, 1, 0, 16'h0, 1, 8'h77, 0);
        chk("R9", "capture blocked by start-of-cycle full", full, 0);
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 16'h0, 1, 8'h0, 1);

        // mixed traffic against the model
        for (int i = 0; i < 600; i++)
            cyc(($urandom % 8) != 0, $urandom % 2, ($urandom % 3) == 0,
                ($urandom % 3) == 0, 16'($urandom), ($urandom % 3) == 0,
                8'($urandom), ($urandom % 6) == 0);
        idle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule